// File: doc/BRIEF.md
# DMA Channel Control, Status and Interrupt Register Block

This block is the software-visible control and status face of one channel of a descriptor-driven copy/XOR engine. Software reaches it through a plain 32-bit register port. The control word turns the channel on and raises a resume request that tells the descriptor sequencer to re-read the chain. The sequencer acknowledges the request. The status word shows a live busy flag taken straight from the engine. It also holds six sticky event flags that one-cycle pulses from the engine set: transfer done, chain done, and four separate error causes.

Software clears a status flag by writing a one to its bit position. Three level interrupt lines come from the flags. Transfer-done and chain-done each drive their own line. The error line is raised while any of the four error causes is held. Descriptor fetching and the data path live elsewhere. Only the two register offsets are decoded here.

Top module: `dmach_ctlstat`

## Requirements
- R1: While reset is asserted, and after it is released, every control and status flag reads 0, ctl_enable and ctl_append are 0, and all three interrupt lines are low.
- R2: The control word is at offset 0x0 and the status word at offset 0x4. A read of any other offset returns 0, and a write to any other offset changes no state.
- R3: Control bit 0 is the channel enable. A write to offset 0x0 loads it from write-data bit 0, and ctl_enable shows the new value from the next cycle on.
- R4: Control bit 1 is the resume request. A write to 0x0 with data bit 1 = 1 sets it, and a write with data bit 1 = 0 leaves it unchanged. It clears in the cycle after eng_append_ack is high. If a setting write and an acknowledge arrive in the same cycle, it stays set. ctl_append mirrors the bit.
- R5: Status bit 13 reads the eng_busy input in the same cycle. It is read-only, and writes have no effect on it.
- R6: Status bit 12 (transfer done) is set from the cycle after an ev_xfer_done pulse and holds until software writes 1 to bit 12 at offset 0x4.
- R7: Status bit 11 (chain done) is set from the cycle after an ev_chain_done pulse and holds until software writes 1 to bit 11 at offset 0x4.
- R8: Status bits 9 (internal parity), 5 (memory controller abort), 4 (internal target abort) and 3 (internal master abort) are each set by their own event input and cleared by writing 1 to their own bit. Writing 0 to a bit leaves it unchanged. All other status bits read 0.
- R9: When an event pulse and a clearing write reach the same status flag in the same cycle, the flag is set afterwards.
- R10: irq_xfer follows status bit 12 and irq_chain follows status bit 11. irq_err is high while any of status bits 9, 5, 4 or 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for reg_addr, combinational |
| eng_busy | input | 1 | Live busy indication from the engine |
| eng_append_ack | input | 1 | Sequencer has taken the resume request |
| ev_xfer_done | input | 1 | Pulse: one descriptor finished |
| ev_chain_done | input | 1 | Pulse: descriptor chain finished |
| ev_err_parity | input | 1 | Pulse: internal parity error |
| ev_err_mcabort | input | 1 | Pulse: memory controller abort |
| ev_err_tabort | input | 1 | Pulse: internal target abort |
| ev_err_mabort | input | 1 | Pulse: internal master abort |
| ctl_enable | output | 1 | Channel enable to the engine |
| ctl_append | output | 1 | Resume request to the sequencer |
| irq_xfer | output | 1 | Transfer-done interrupt, level |
| irq_chain | output | 1 | Chain-done interrupt, level |
| irq_err | output | 1 | Error interrupt, level |

## Verification
Read data and the busy flag are combinational, so they are due in the same cycle as the address or the eng_busy change. Every write, event pulse and acknowledge becomes visible exactly one clock edge later, on the registered flags, on the control outputs and on the interrupt lines. The bench drives inputs just after the falling edge and advances a behavioural model on each rising edge. It compares every output against that model at the following falling edge, so each result is checked in the first cycle it is due and in every cycle after.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  // Register offsets (byte addresses)
  localparam int CTRL_OFS    = 'h0;
  localparam int STAT_OFS    = 'h4;

  // Control word fields
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_APP_BIT = 1;

  // Status word fields
  localparam int ST_BUSY_BIT = 13;

  // Sticky flags, ordered by index
  localparam int NUM_STICKY  = 6;
  localparam int ERR_FIRST   = 2;   // indices ERR_FIRST.. are error causes
  localparam int NUM_ERR     = NUM_STICKY - ERR_FIRST;

  typedef enum logic [2:0] {
    SB_XFER   = 3'd0,
    SB_CHAIN  = 3'd1,
    SB_PARITY = 3'd2,
    SB_MCABRT = 3'd3,
    SB_TABRT  = 3'd4,
    SB_MABRT  = 3'd5
  } sticky_idx_e;

  // Status bit position of each sticky flag
  function automatic int sticky_pos(input int idx);
    case (idx)
      SB_XFER:   return 12;
      SB_CHAIN:  return 11;
      SB_PARITY: return 9;
      SB_MCABRT: return 5;
      SB_TABRT:  return 4;
      default:   return 3;
    endcase
  endfunction

endpackage

// File: rtl/dmach_sticky_bit.sv
module dmach_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_q;
  logic q_d;
  logic q_ce;

  // set has priority so an event coinciding with a clear survives
  always_comb begin
    q_ce = set_i | clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else if (q_ce) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  // R9: event beats a same-cycle clear
  assert_set_wins_R9: assert property (
    @(posedge clk) disable iff (!rst_n) set_i |=> q_o)
    else $error("sticky flag lost a set");

  // R6, R7, R8: a write of 1 with no event clears the flag
  assert_w1c_clear_R8: assert property (
    @(posedge clk) disable iff (!rst_n) (clr_i && !set_i) |=> !q_o)
    else $error("sticky flag not cleared");

  // R8: without set or clear the flag holds
  assert_hold_R8: assert property (
    @(posedge clk) disable iff (!rst_n) (!set_i && !clr_i) |=> $stable(q_o))
    else $error("sticky flag changed on its own");

endmodule

// File: rtl/dmach_ctrl_reg.sv
module dmach_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wen_val_i,
  input  logic wapp_val_i,
  input  logic ack_i,
  output logic en_o,
  output logic app_o
);

  logic en_q, en_d, en_ce;
  logic app_q, app_d, app_ce;

  always_comb begin
    en_ce  = wr_i;
    en_d   = wen_val_i;
    // request set by software has priority over the sequencer acknowledge
    app_ce = (wr_i & wapp_val_i) | ack_i;
    app_d  = wr_i & wapp_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_q <= 1'b0;
    end else if (app_ce) begin
      app_q <= app_d;
    end
  end

  assign en_o  = en_q;
  assign app_o = app_q;

  assert_enable_load_R3: assert property (
    @(posedge clk) disable iff (!rst_n) wr_i |=> (en_o == $past(wen_val_i)))
    else $error("enable not loaded");

  assert_append_set_R4: assert property (
    @(posedge clk) disable iff (!rst_n) (wr_i && wapp_val_i) |=> app_o)
    else $error("resume request not set");

  assert_append_ack_R4: assert property (
    @(posedge clk) disable iff (!rst_n) (ack_i && !(wr_i && wapp_val_i)) |=> !app_o)
    else $error("resume request not cleared by acknowledge");

endmodule

// File: rtl/dmach_rd_mux.sv
module dmach_rd_mux #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_STICKY = dmach_pkg::NUM_STICKY
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  en_i,
  input  logic                  app_i,
  input  logic                  busy_i,
  input  logic [NUM_STICKY-1:0] sticky_i,
  output logic [DATA_W-1:0]     rdata_o
);
  import dmach_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[CTL_EN_BIT]  = en_i;
      rdata_o[CTL_APP_BIT] = app_i;
    end else if (addr_i == A_STAT) begin
      rdata_o[ST_BUSY_BIT] = busy_i;
      for (int k = 0; k < NUM_STICKY; k++) begin
        rdata_o[sticky_pos(k)] = sticky_i[k];
      end
    end
  end

endmodule

// File: rtl/dmach_ctlstat.sv
module dmach_ctlstat #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_append_ack,
  input  logic              ev_xfer_done,
  input  logic              ev_chain_done,
  input  logic              ev_err_parity,
  input  logic              ev_err_mcabort,
  input  logic              ev_err_tabort,
  input  logic              ev_err_mabort,
  output logic              ctl_enable,
  output logic              ctl_append,
  output logic              irq_xfer,
  output logic              irq_chain,
  output logic              irq_err
);
  import dmach_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  logic                  wr_ctrl;
  logic                  wr_stat;
  logic [NUM_STICKY-1:0] st_set;
  logic [NUM_STICKY-1:0] st_clr;
  logic [NUM_STICKY-1:0] st_q;
  logic                  unused_wdata;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign unused_wdata = ^reg_wdata;

  // event inputs in sticky index order
  assign st_set[SB_XFER]   = ev_xfer_done;
  assign st_set[SB_CHAIN]  = ev_chain_done;
  assign st_set[SB_PARITY] = ev_err_parity;
  assign st_set[SB_MCABRT] = ev_err_mcabort;
  assign st_set[SB_TABRT]  = ev_err_tabort;
  assign st_set[SB_MABRT]  = ev_err_mabort;

  dmach_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_ctrl),
    .wen_val_i  (reg_wdata[CTL_EN_BIT]),
    .wapp_val_i (reg_wdata[CTL_APP_BIT]),
    .ack_i      (eng_append_ack),
    .en_o       (ctl_enable),
    .app_o      (ctl_append)
  );

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    localparam int POS = sticky_pos(i);
    assign st_clr[i] = wr_stat & reg_wdata[POS];
    dmach_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set[i]),
      .clr_i (st_clr[i]),
      .q_o   (st_q[i])
    );
  end

  dmach_rd_mux #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_STICKY (NUM_STICKY)
  ) u_rd (
    .addr_i   (reg_addr),
    .en_i     (ctl_enable),
    .app_i    (ctl_append),
    .busy_i   (eng_busy),
    .sticky_i (st_q),
    .rdata_o  (reg_rdata)
  );

  assign irq_xfer  = st_q[SB_XFER];
  assign irq_chain = st_q[SB_CHAIN];
  assign irq_err   = |st_q[NUM_STICKY-1:ERR_FIRST];

  // R10: any error event raises the error line on the next cycle
  assert_err_irq_rise_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
      (ev_err_parity || ev_err_mcabort || ev_err_tabort || ev_err_mabort) |=> irq_err)
    else $error("error interrupt missing");

  // R10: transfer-done pulse raises its line on the next cycle
  assert_xfer_irq_rise_R10: assert property (
    @(posedge clk) disable iff (!rst_n) ev_xfer_done |=> irq_xfer)
    else $error("transfer interrupt missing");

  // R5: status readback tracks the busy input
  assert_busy_live_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
      (reg_addr == A_STAT) |-> (reg_rdata[ST_BUSY_BIT] == eng_busy))
    else $error("busy readback wrong");

  // R2: writes to undecoded offsets leave all state alone
  assert_offmap_write_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr != A_CTRL && reg_addr != A_STAT && !eng_append_ack &&
       !ev_xfer_done && !ev_chain_done && !ev_err_parity && !ev_err_mcabort &&
       !ev_err_tabort && !ev_err_mabort)
      |=> ($stable(ctl_enable) && $stable(ctl_append) && $stable(irq_xfer) &&
           $stable(irq_chain) && $stable(irq_err)))
    else $error("write to undecoded offset changed state");

endmodule

// File: tb/sim_dmach_ctlstat.sv
`timescale 1ns/100ps
module sim_dmach_ctlstat;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        eng_busy;
  logic        eng_append_ack;
  logic        ev_xfer_done, ev_chain_done;
  logic        ev_err_parity, ev_err_mcabort, ev_err_tabort, ev_err_mabort;
  logic        ctl_enable, ctl_append, irq_xfer, irq_chain, irq_err;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    n_cycles = 0;
  bit    running  = 0;
  string phase    = "R1";

  dmach_ctlstat u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .eng_append_ack(eng_append_ack), .ev_xfer_done(ev_xfer_done),
    .ev_chain_done(ev_chain_done), .ev_err_parity(ev_err_parity),
    .ev_err_mcabort(ev_err_mcabort), .ev_err_tabort(ev_err_tabort),
    .ev_err_mabort(ev_err_mabort), .ctl_enable(ctl_enable),
    .ctl_append(ctl_append), .irq_xfer(irq_xfer), .irq_chain(irq_chain),
    .irq_err(irq_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  // ---------------- behavioural reference model ----------------
  bit m_en, m_app;
  bit m_eot, m_eoc, m_par, m_mca, m_tab, m_mab;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_app = 0;
      m_eot = 0; m_eoc = 0; m_par = 0; m_mca = 0; m_tab = 0; m_mab = 0;
    end else begin
      bit wc, ws;
      wc = reg_wr && reg_addr == 8'h00;
      ws = reg_wr && reg_addr == 8'h04;
      if (wc) m_en = reg_wdata[0];
      if (wc && reg_wdata[1]) m_app = 1;
      else if (eng_append_ack) m_app = 0;
      if (ev_xfer_done)   m_eot = 1; else if (ws && reg_wdata[12]) m_eot = 0;
      if (ev_chain_done)  m_eoc = 1; else if (ws && reg_wdata[11]) m_eoc = 0;
      if (ev_err_parity)  m_par = 1; else if (ws && reg_wdata[9])  m_par = 0;
      if (ev_err_mcabort) m_mca = 1; else if (ws && reg_wdata[5])  m_mca = 0;
      if (ev_err_tabort)  m_tab = 1; else if (ws && reg_wdata[4])  m_tab = 0;
      if (ev_err_mabort)  m_mab = 1; else if (ws && reg_wdata[3])  m_mab = 0;
    end
  end

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r;
    r = '0;
    if (reg_addr == 8'h00) begin
      r[0] = m_en; r[1] = m_app;
    end else if (reg_addr == 8'h04) begin
      r[13] = eng_busy; r[12] = m_eot; r[11] = m_eoc;
      r[9] = m_par; r[5] = m_mca; r[4] = m_tab; r[3] = m_mab;
    end
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h",
               req, what, n_cycles, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      check(phase, "reg_rdata", reg_rdata, exp_rdata());
      check("R3", "ctl_enable", {31'b0, ctl_enable}, {31'b0, m_en});
      check("R4", "ctl_append", {31'b0, ctl_append}, {31'b0, m_app});
      check("R10", "irq_xfer", {31'b0, irq_xfer}, {31'b0, m_eot});
      check("R10", "irq_chain", {31'b0, irq_chain}, {31'b0, m_eoc});
      check("R10", "irq_err", {31'b0, irq_err},
            {31'b0, (m_par | m_mca | m_tab | m_mab)});
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cycles++;
    if (n_cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", n_cycles);
      finish_run();
    end
  end

  // ev bit order: 0 xfer, 1 chain, 2 parity, 3 mc abort, 4 target abort, 5 master abort
  task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d,
                     input logic [5:0] ev, input bit ack);
    reg_wr = w; reg_addr = a; reg_wdata = d; eng_append_ack = ack;
    {ev_err_mabort, ev_err_tabort, ev_err_mcabort,
     ev_err_parity, ev_chain_done, ev_xfer_done} = ev;
    @(negedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(0, a, 32'h0, 6'h0, 0);
  endtask

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; eng_busy = 0;
    eng_append_ack = 0; ev_xfer_done = 0; ev_chain_done = 0;
    ev_err_parity = 0; ev_err_mcabort = 0; ev_err_tabort = 0; ev_err_mabort = 0;
    repeat (3) @(negedge clk);
    #1;
    running = 1;
    phase = "R1";
    rd(8'h00); rd(8'h04);            // reset state, reset still held
    rst_n = 1;
    rd(8'h00); rd(8'h04);

    phase = "R2";
    cyc(1, 8'h08, 32'hFFFF_FFFF, 6'h0, 0);
    cyc(1, 8'h0C, 32'hFFFF_FFFF, 6'h0, 0);
    cyc(1, 8'h01, 32'hFFFF_FFFF, 6'h0, 0);
    rd(8'h08); rd(8'h00); rd(8'h04);

    phase = "R3";
    cyc(1, 8'h00, 32'h1, 6'h0, 0);
    rd(8'h00);
    cyc(1, 8'h00, 32'h0, 6'h0, 0);
    rd(8'h00);
    cyc(1, 8'h00, 32'hFFFF_FFFD, 6'h0, 0);   // enable on, request bit 0
    rd(8'h00);

    phase = "R4";
    cyc(1, 8'h00, 32'h3, 6'h0, 0);
    rd(8'h00);
    cyc(1, 8'h00, 32'h1, 6'h0, 0);   // writing 0 to request leaves it set
    rd(8'h00); rd(8'h00);
    cyc(0, 8'h00, 32'h0, 6'h0, 1);   // acknowledge
    rd(8'h00);
    cyc(1, 8'h00, 32'h3, 6'h0, 1);   // set and acknowledge together
    rd(8'h00);
    cyc(0, 8'h00, 32'h0, 6'h0, 1);
    rd(8'h00);

    phase = "R5";
    eng_busy = 1;
    rd(8'h04);
    cyc(1, 8'h04, 32'h2000, 6'h0, 0);
    rd(8'h04);
    eng_busy = 0;
    cyc(1, 8'h04, 32'hFFFF_FFFF, 6'h0, 0);
    rd(8'h04);

    phase = "R6";
    cyc(0, 8'h04, 32'h0, 6'h01, 0);
    rd(8'h04);
    cyc(1, 8'h04, ~(32'h1 << 12), 6'h0, 0);  // other bits only
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 12, 6'h0, 0);
    rd(8'h04);

    phase = "R7";
    cyc(0, 8'h04, 32'h0, 6'h02, 0);
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 12, 6'h0, 0);     // wrong bit, stays
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 11, 6'h0, 0);
    rd(8'h04);

    phase = "R8";
    cyc(0, 8'h04, 32'h0, 6'h3C, 0);
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 9, 6'h0, 0);
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 5, 6'h0, 0);
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 4, 6'h0, 0);
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 3, 6'h0, 0);
    rd(8'h04);
    for (int k = 2; k < 6; k++) begin
      cyc(0, 8'h04, 32'h0, 6'(1 << k), 0);
      rd(8'h04);
      cyc(1, 8'h04, 32'h0, 6'h0, 0);
      rd(8'h04);
      cyc(1, 8'h04, 32'h0000_0238, 6'h0, 0);
      rd(8'h04);
    end

    phase = "R9";
    cyc(0, 8'h04, 32'h0, 6'h01, 0);
    cyc(1, 8'h04, 32'h1 << 12, 6'h01, 0);
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 12, 6'h0, 0);
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 3, 6'h20, 0);
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 3, 6'h0, 0);
    rd(8'h04);

    phase = "R10";
    cyc(0, 8'h04, 32'h0, 6'h03, 0);
    rd(8'h04);
    cyc(1, 8'h04, 32'h1 << 11, 6'h10, 0);
    rd(8'h04);
    cyc(1, 8'h04, 32'h0000_1010, 6'h0, 0);
    rd(8'h04);

    phase = "R1";
    cyc(0, 8'h04, 32'h0, 6'h3F, 0);
    cyc(1, 8'h00, 32'h3, 6'h0, 0);
    rd(8'h04);
    rst_n = 0;
    rd(8'h04); rd(8'h00);
    rst_n = 1;
    rd(8'h00); rd(8'h04);

    running = 0;
    finish_run();
  end

endmodule